// File: doc/BRIEF.md
# Endpoint Bank Tracker

This block keeps the bank bookkeeping for a single USB device endpoint whose packet data lives in up to three banks of a shared packet memory. The USB side reports each finished transaction with a one-cycle pulse, and for OUT traffic it also gives the received length. The processor side fills or drains the current bank one byte per strobe and hands the bank back with a release strobe. It can also hold off access with stall or error levels, and it sets up the endpoint with an allocation strobe.

From this state the block derives the number of occupied banks, the bank the processor is working on, whether that bank may be accessed now, how many bytes it holds, and whether the last allocation was legal. It also raises a bank-level interrupt and keeps the data direction announced by the most recent SETUP packet. Banks are used in strict rotation. A release only takes effect after a fixed pipeline delay, which models the time the block needs to work out the next bank address.

Top module: `ep_bank_mgr`

## Requirements
- R1: After reset, busy_cnt, cur_bank, byte_cnt, rw_allowed, bank_int, cfg_ok and ctrl_dir are all 0.
- R2: A cfg_alloc pulse empties every bank and sets both pointers to bank 0. From the next cycle, cfg_ok is 1 only if all of these hold: cfg_banks is from 1 to MAX_BANKS, the bank size (8 << cfg_size_code) is at most MAX_SIZE, and banks times size is at most MEM_BYTES. While cfg_ok is 0, busy_cnt stays 0 and every transaction and processor strobe is ignored.
- R3: On an IN endpoint, rw_allowed is 1 while the current bank is not busy and byte_cnt is below the bank size. Each clock with cpu_wr and rw_allowed both high adds one to byte_cnt, so byte_cnt never goes past the bank size.
- R4: A cpu_release is accepted when the current bank belongs to the processor: on IN that means not busy, on OUT it means busy. rw_allowed is 0 from the first edge after an accepted release. busy_cnt and cur_bank change only at the second edge after the one that sampled the strobe. Releases that arrive while one is still pending are ignored.
- R5: cur_bank and the USB-side bank both step 0, 1, 2 and wrap to 0 after bank cfg_banks-1.
- R6: On an IN endpoint, usb_done frees the oldest busy bank. It is ignored when no bank is busy.
- R7: On an OUT endpoint, usb_done fills the next free bank with usb_len bytes, limited to the bank size. It is ignored when every bank is busy. busy_cnt counts the received banks that have not yet been released.
- R8: On an OUT endpoint, byte_cnt shows the unread bytes of the current bank. rw_allowed is 1 while that bank is busy and byte_cnt is not 0, and each clock with cpu_rd and rw_allowed both high takes one from byte_cnt.
- R9: While stall_req or err_flag is high, rw_allowed is 0 in that same cycle and cpu_wr and cpu_rd have no effect.
- R10: When the endpoint was allocated as a control endpoint (cfg_ctrl = 1), rw_allowed stays 0.
- R11: bank_int is 1, in the same cycle as busy_cnt, when int_en and cfg_ok are 1 and either the endpoint is IN with busy_cnt 0, or it is OUT with busy_cnt equal to cfg_banks.
- R12: A setup_done pulse loads ctrl_dir from setup_dir_in, where 0 means the next packet is OUT and 1 means it is IN. No other input, allocation included, changes ctrl_dir.
- R13: cur_bank encodes bank 0, 1 and 2 as 00, 01 and 10. The code 11 never appears.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cfg_alloc | input | 1 | Allocation strobe, latches the cfg_* fields |
| cfg_banks | input | 2 | Requested bank count |
| cfg_size_code | input | 3 | Bank size code, size = 8 << code bytes |
| cfg_dir_in | input | 1 | 1 = IN endpoint, 0 = OUT endpoint |
| cfg_ctrl | input | 1 | 1 = control endpoint |
| int_en | input | 1 | Bank interrupt enable |
| usb_done | input | 1 | USB transaction completed (one cycle) |
| usb_len | input | CW = $clog2(MAX_SIZE+1) | Byte count received by an OUT transaction |
| setup_done | input | 1 | SETUP packet completed (one cycle) |
| setup_dir_in | input | 1 | Direction of the stage following SETUP |
| cpu_wr | input | 1 | Processor writes one byte (IN) |
| cpu_rd | input | 1 | Processor reads one byte (OUT) |
| cpu_release | input | 1 | Processor hands the current bank back |
| stall_req | input | 1 | Stall requested |
| err_flag | input | 1 | Error present |
| busy_cnt | output | BW = $clog2(MAX_BANKS+1) | Number of busy banks |
| cur_bank | output | 2 | Processor's current bank |
| rw_allowed | output | 1 | Current bank may be accessed |
| byte_cnt | output | CW | Bytes in the current bank |
| cfg_ok | output | 1 | Last allocation was legal |
| bank_int | output | 1 | Bank-status interrupt |
| ctrl_dir | output | 1 | Direction captured after SETUP |

## Verification
The bench builds the block with MAX_BANKS = 3, MAX_SIZE = 16 and MEM_BYTES = 32. With 8-byte banks, three IN banks fill with a handful of strobes. This lets the bench reach full banks and the wrap from bank 2 back to 0, and it reaches size clamping of an oversized OUT packet in few cycles. The same values put the legality check on its edges: two 16-byte banks exactly fill the memory, three of them overflow it, and a 32-byte bank is over the per-bank limit. The release pipeline is probed cycle by cycle, and the full and empty interrupt conditions are reached in both directions.

// File: rtl/ep_bank_pkg.sv
package ep_bank_pkg;

    // Smallest bank size; a size code shifts it left.
    localparam int unsigned BASE_BYTES = 8;

    typedef enum logic {
        DIR_OUT = 1'b0,
        DIR_IN  = 1'b1
    } ep_dir_e;

    // Rotate a bank index, wrapping after bank (n-1).
    function automatic logic [1:0] ring_next(input logic [1:0] p, input logic [1:0] n);
        return (p == (n - 2'd1)) ? 2'd0 : (p + 2'd1);
    endfunction

endpackage

// File: rtl/ep_cfg_check.sv
module ep_cfg_check #(
    parameter int MAX_BANKS = 3,
    parameter int MAX_SIZE  = 64,
    parameter int MEM_BYTES = 128,
    localparam int CW = $clog2(MAX_SIZE + 1)
) (
    input  logic [1:0]    banks,
    input  logic [2:0]    size_code,
    output logic          legal,
    output logic [CW-1:0] size_bytes
);
    import ep_bank_pkg::*;

    logic [31:0] size_w;
    logic [31:0] total_w;

    always_comb begin
        size_w  = 32'(BASE_BYTES) << size_code;
        total_w = 32'(banks) * size_w;
        legal   = (banks != 2'd0)
               && (32'(banks) <= 32'(MAX_BANKS))
               && (size_w <= 32'(MAX_SIZE))
               && (total_w <= 32'(MEM_BYTES));
        size_bytes = legal ? CW'(size_w) : '0;
    end

endmodule

// File: rtl/ep_rel_delay.sv
module ep_rel_delay #(
    parameter int DEPTH = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic clr,
    input  logic take,
    output logic apply,
    output logic pending
);
    logic [DEPTH-1:0] sr_d, sr_q;

    always_comb begin
        sr_d[0] = take;
        for (int i = 1; i < DEPTH; i++) begin
            sr_d[i] = sr_q[i-1];
        end
        if (clr) begin
            sr_d = '0;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            sr_q <= '0;
        end else begin
            sr_q <= sr_d;
        end
    end

    assign apply   = sr_q[DEPTH-1];
    assign pending = |sr_q;

endmodule

// File: rtl/ep_busy_count.sv
module ep_busy_count #(
    parameter int N = 3,
    localparam int BW = $clog2(N + 1)
) (
    input  logic [N-1:0]  busy,
    output logic [BW-1:0] count
);
    logic [BW-1:0] part [N+1];

    assign part[0] = '0;
    for (genvar i = 0; i < N; i++) begin : g_sum
        assign part[i+1] = part[i] + BW'(busy[i]);
    end
    assign count = part[N];

endmodule

// File: rtl/ep_bank_mgr.sv
module ep_bank_mgr
    import ep_bank_pkg::*;
#(
    parameter int MAX_BANKS = 3,
    parameter int MAX_SIZE  = 64,
    parameter int MEM_BYTES = 128,
    parameter int REL_DELAY = 2,
    localparam int CW = $clog2(MAX_SIZE + 1),
    localparam int BW = $clog2(MAX_BANKS + 1)
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          cfg_alloc,
    input  logic [1:0]    cfg_banks,
    input  logic [2:0]    cfg_size_code,
    input  logic          cfg_dir_in,
    input  logic          cfg_ctrl,
    input  logic          int_en,
    input  logic          usb_done,
    input  logic [CW-1:0] usb_len,
    input  logic          setup_done,
    input  logic          setup_dir_in,
    input  logic          cpu_wr,
    input  logic          cpu_rd,
    input  logic          cpu_release,
    input  logic          stall_req,
    input  logic          err_flag,
    output logic [BW-1:0] busy_cnt,
    output logic [1:0]    cur_bank,
    output logic          rw_allowed,
    output logic [CW-1:0] byte_cnt,
    output logic          cfg_ok,
    output logic          bank_int,
    output logic          ctrl_dir
);

    typedef struct packed {
        logic [MAX_BANKS-1:0]         busy;
        logic [MAX_BANKS-1:0][CW-1:0] cnt;
        logic [1:0]                   cpu_ptr;
        logic [1:0]                   usb_ptr;
        logic [1:0]                   nbanks;
        logic [CW-1:0]                bsize;
        ep_dir_e                      dir;
        logic                         is_ctrl;
        logic                         ok;
        logic                         cdir;
    } st_t;

    st_t st_d, st_q;

    logic          chk_legal;
    logic [CW-1:0] chk_size;
    logic          rel_take;
    logic          rel_apply;
    logic          rel_pending;
    logic          cur_busy;
    logic [CW-1:0] cur_cnt;
    logic          usb_busy;
    logic          access_open;
    logic          blocked;
    logic          rw_int;
    logic [CW-1:0] len_clamped;

    ep_cfg_check #(
        .MAX_BANKS (MAX_BANKS),
        .MAX_SIZE  (MAX_SIZE),
        .MEM_BYTES (MEM_BYTES)
    ) u_cfg (
        .banks      (cfg_banks),
        .size_code  (cfg_size_code),
        .legal      (chk_legal),
        .size_bytes (chk_size)
    );

    ep_rel_delay #(
        .DEPTH (REL_DELAY)
    ) u_rel (
        .clk     (clk),
        .rst_n   (rst_n),
        .clr     (cfg_alloc),
        .take    (rel_take),
        .apply   (rel_apply),
        .pending (rel_pending)
    );

    ep_busy_count #(
        .N (MAX_BANKS)
    ) u_cnt (
        .busy  (st_q.busy),
        .count (busy_cnt)
    );

    // Next-state computation
    always_comb begin
        st_d = st_q;

        cur_busy = 1'b0;
        cur_cnt  = '0;
        usb_busy = 1'b0;
        for (int b = 0; b < MAX_BANKS; b++) begin
            if (2'(b) == st_q.cpu_ptr) begin
                cur_busy = st_q.busy[b];
                cur_cnt  = st_q.cnt[b];
            end
            if (2'(b) == st_q.usb_ptr) begin
                usb_busy = st_q.busy[b];
            end
        end

        if (st_q.dir == DIR_IN) begin
            access_open = !cur_busy && (cur_cnt < st_q.bsize);
        end else begin
            access_open = cur_busy && (cur_cnt != '0);
        end

        blocked = stall_req || err_flag || st_q.is_ctrl || rel_pending || !st_q.ok;
        rw_int  = !blocked && access_open;

        rel_take = cpu_release && st_q.ok && !rel_pending
                && ((st_q.dir == DIR_IN) ? !cur_busy : cur_busy);

        len_clamped = (usb_len > st_q.bsize) ? st_q.bsize : usb_len;

        if (cfg_alloc) begin
            st_d.busy    = '0;
            st_d.cnt     = '0;
            st_d.cpu_ptr = 2'd0;
            st_d.usb_ptr = 2'd0;
            st_d.nbanks  = cfg_banks;
            st_d.bsize   = chk_size;
            st_d.dir     = ep_dir_e'(cfg_dir_in);
            st_d.is_ctrl = cfg_ctrl;
            st_d.ok      = chk_legal;
        end else begin
            // USB side
            if (st_q.ok && usb_done) begin
                if (st_q.dir == DIR_IN) begin
                    if (usb_busy) begin
                        for (int b = 0; b < MAX_BANKS; b++) begin
                            if (2'(b) == st_q.usb_ptr) begin
                                st_d.busy[b] = 1'b0;
                                st_d.cnt[b]  = '0;
                            end
                        end
                        st_d.usb_ptr = ring_next(st_q.usb_ptr, st_q.nbanks);
                    end
                end else begin
                    if (!usb_busy) begin
                        for (int b = 0; b < MAX_BANKS; b++) begin
                            if (2'(b) == st_q.usb_ptr) begin
                                st_d.busy[b] = 1'b1;
                                st_d.cnt[b]  = len_clamped;
                            end
                        end
                        st_d.usb_ptr = ring_next(st_q.usb_ptr, st_q.nbanks);
                    end
                end
            end

            // Processor byte access
            for (int b = 0; b < MAX_BANKS; b++) begin
                if (2'(b) == st_q.cpu_ptr) begin
                    if (rw_int && cpu_wr && (st_q.dir == DIR_IN)) begin
                        st_d.cnt[b] = cur_cnt + CW'(1);
                    end
                    if (rw_int && cpu_rd && (st_q.dir == DIR_OUT)) begin
                        st_d.cnt[b] = cur_cnt - CW'(1);
                    end
                end
            end

            // Delayed bank hand-over
            if (rel_apply) begin
                for (int b = 0; b < MAX_BANKS; b++) begin
                    if (2'(b) == st_q.cpu_ptr) begin
                        if (st_q.dir == DIR_IN) begin
                            st_d.busy[b] = 1'b1;
                        end else begin
                            st_d.busy[b] = 1'b0;
                            st_d.cnt[b]  = '0;
                        end
                    end
                end
                st_d.cpu_ptr = ring_next(st_q.cpu_ptr, st_q.nbanks);
            end
        end

        if (setup_done) begin
            st_d.cdir = setup_dir_in;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign cur_bank   = st_q.cpu_ptr;
    assign byte_cnt   = cur_cnt;
    assign rw_allowed = rw_int;
    assign cfg_ok     = st_q.ok;
    assign ctrl_dir   = st_q.cdir;
    assign bank_int   = st_q.ok && int_en
                     && ((st_q.dir == DIR_IN) ? (busy_cnt == '0)
                                              : (32'(busy_cnt) == 32'(st_q.nbanks)));

endmodule

// File: rtl/ep_bank_mgr_chk.sv
module ep_bank_mgr_chk #(
    parameter int MAX_BANKS = 3,
    parameter int MAX_SIZE  = 64,
    parameter int CW        = 7,
    parameter int BW        = 2
) (
    input logic          clk,
    input logic          rst_n,
    input logic          cfg_alloc,
    input logic          setup_done,
    input logic          stall_req,
    input logic          err_flag,
    input logic [BW-1:0] busy_cnt,
    input logic [1:0]    cur_bank,
    input logic          rw_allowed,
    input logic [CW-1:0] byte_cnt,
    input logic          cfg_ok,
    input logic          bank_int,
    input logic          ctrl_dir
);

    assert_cur_bank_code_R13: assert property (@(posedge clk) disable iff (!rst_n)
        cur_bank != 2'b11);

    assert_stall_blocks_R9: assert property (@(posedge clk) disable iff (!rst_n)
        (stall_req || err_flag) |-> !rw_allowed);

    assert_ctrl_dir_hold_R12: assert property (@(posedge clk) disable iff (!rst_n)
        !$past(setup_done) |-> $stable(ctrl_dir));

    assert_cfg_hold_R2: assert property (@(posedge clk) disable iff (!rst_n)
        !$past(cfg_alloc) |-> $stable(cfg_ok));

    assert_idle_empty_R2: assert property (@(posedge clk) disable iff (!rst_n)
        !cfg_ok |-> (busy_cnt == '0));

    assert_int_gate_R11: assert property (@(posedge clk) disable iff (!rst_n)
        bank_int |-> cfg_ok);

    assert_busy_bound_R7: assert property (@(posedge clk) disable iff (!rst_n)
        32'(busy_cnt) <= 32'(MAX_BANKS));

    assert_byte_bound_R3: assert property (@(posedge clk) disable iff (!rst_n)
        32'(byte_cnt) <= 32'(MAX_SIZE));

endmodule

bind ep_bank_mgr ep_bank_mgr_chk #(
    .MAX_BANKS (MAX_BANKS),
    .MAX_SIZE  (MAX_SIZE),
    .CW        (CW),
    .BW        (BW)
) u_chk (
    .clk        (clk),
    .rst_n      (rst_n),
    .cfg_alloc  (cfg_alloc),
    .setup_done (setup_done),
    .stall_req  (stall_req),
    .err_flag   (err_flag),
    .busy_cnt   (busy_cnt),
    .cur_bank   (cur_bank),
    .rw_allowed (rw_allowed),
    .byte_cnt   (byte_cnt),
    .cfg_ok     (cfg_ok),
    .bank_int   (bank_int),
    .ctrl_dir   (ctrl_dir)
);

// File: tb/ep_bank_mgr_tb_top.sv
module ep_bank_mgr_tb_top;

    localparam int MB = 3;
    localparam int MS = 16;
    localparam int ME = 32;
    localparam int CW = $clog2(MS + 1);
    localparam int BW = $clog2(MB + 1);

    localparam logic [2:0] OP_ALLOC = 3'd1;
    localparam logic [2:0] OP_WR    = 3'd2;
    localparam logic [2:0] OP_RD    = 3'd3;
    localparam logic [2:0] OP_REL   = 3'd4;
    localparam logic [2:0] OP_USB   = 3'd5;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic cfg_alloc = 1'b0;
    logic [1:0] cfg_banks = '0;
    logic [2:0] cfg_size_code = '0;
    logic cfg_dir_in = 1'b0;
    logic cfg_ctrl = 1'b0;
    logic int_en = 1'b1;
    logic usb_done = 1'b0;
    logic [CW-1:0] usb_len = '0;
    logic setup_done = 1'b0;
    logic setup_dir_in = 1'b0;
    logic cpu_wr = 1'b0;
    logic cpu_rd = 1'b0;
    logic cpu_release = 1'b0;
    logic stall_req = 1'b0;
    logic err_flag = 1'b0;
    logic [BW-1:0] busy_cnt;
    logic [1:0] cur_bank;
    logic rw_allowed;
    logic [CW-1:0] byte_cnt;
    logic cfg_ok;
    logic bank_int;
    logic ctrl_dir;

    int total = 0;
    int bad = 0;

    always #2.5 clk = ~clk;

    ep_bank_mgr #(
        .MAX_BANKS (MB),
        .MAX_SIZE  (MS),
        .MEM_BYTES (ME)
    ) dut_i (
        .clk (clk), .rst_n (rst_n),
        .cfg_alloc (cfg_alloc), .cfg_banks (cfg_banks), .cfg_size_code (cfg_size_code),
        .cfg_dir_in (cfg_dir_in), .cfg_ctrl (cfg_ctrl), .int_en (int_en),
        .usb_done (usb_done), .usb_len (usb_len),
        .setup_done (setup_done), .setup_dir_in (setup_dir_in),
        .cpu_wr (cpu_wr), .cpu_rd (cpu_rd), .cpu_release (cpu_release),
        .stall_req (stall_req), .err_flag (err_flag),
        .busy_cnt (busy_cnt), .cur_bank (cur_bank), .rw_allowed (rw_allowed),
        .byte_cnt (byte_cnt), .cfg_ok (cfg_ok), .bank_int (bank_int), .ctrl_dir (ctrl_dir)
    );

    function automatic logic [31:0] mk(input logic [2:0] op, input logic [7:0] arg,
                                       input logic [1:0] eb, input logic [1:0] ec,
                                       input logic [4:0] ey, input logic er,
                                       input logic ei, input logic eo);
        return {op, arg, eb, ec, ey, er, ei, eo, 9'd0};
    endfunction

    function automatic logic [7:0] alc(input logic [1:0] n, input logic [2:0] code,
                                       input logic din, input logic ctl);
        return {n, code, din, ctl, 1'b0};
    endfunction

    // op, arg, busy, cur, bytes, rw, int, cfg_ok
    localparam logic [31:0] VEC [30] = '{
        mk(OP_ALLOC, alc(2'd3, 3'd0, 1'b1, 1'b0), 2'd0, 2'd0, 5'd0, 1'b1, 1'b1, 1'b1),
        mk(OP_WR,    8'd5,  2'd0, 2'd0, 5'd5,  1'b1, 1'b1, 1'b1),
        mk(OP_WR,    8'd5,  2'd0, 2'd0, 5'd8,  1'b0, 1'b1, 1'b1),
        mk(OP_REL,   8'd0,  2'd1, 2'd1, 5'd0,  1'b1, 1'b0, 1'b1),
        mk(OP_WR,    8'd2,  2'd1, 2'd1, 5'd2,  1'b1, 1'b0, 1'b1),
        mk(OP_REL,   8'd0,  2'd2, 2'd2, 5'd0,  1'b1, 1'b0, 1'b1),
        mk(OP_REL,   8'd0,  2'd3, 2'd0, 5'd8,  1'b0, 1'b0, 1'b1),
        mk(OP_REL,   8'd0,  2'd3, 2'd0, 5'd8,  1'b0, 1'b0, 1'b1),
        mk(OP_USB,   8'd0,  2'd2, 2'd0, 5'd0,  1'b1, 1'b0, 1'b1),
        mk(OP_USB,   8'd0,  2'd1, 2'd0, 5'd0,  1'b1, 1'b0, 1'b1),
        mk(OP_USB,   8'd0,  2'd0, 2'd0, 5'd0,  1'b1, 1'b1, 1'b1),
        mk(OP_USB,   8'd0,  2'd0, 2'd0, 5'd0,  1'b1, 1'b1, 1'b1),
        mk(OP_ALLOC, alc(2'd2, 3'd1, 1'b0, 1'b0), 2'd0, 2'd0, 5'd0, 1'b0, 1'b0, 1'b1),
        mk(OP_USB,   8'd5,  2'd1, 2'd0, 5'd5,  1'b1, 1'b0, 1'b1),
        mk(OP_USB,   8'd20, 2'd2, 2'd0, 5'd5,  1'b1, 1'b1, 1'b1),
        mk(OP_USB,   8'd3,  2'd2, 2'd0, 5'd5,  1'b1, 1'b1, 1'b1),
        mk(OP_RD,    8'd2,  2'd2, 2'd0, 5'd3,  1'b1, 1'b1, 1'b1),
        mk(OP_RD,    8'd5,  2'd2, 2'd0, 5'd0,  1'b0, 1'b1, 1'b1),
        mk(OP_REL,   8'd0,  2'd1, 2'd1, 5'd16, 1'b1, 1'b0, 1'b1),
        mk(OP_USB,   8'd0,  2'd2, 2'd1, 5'd16, 1'b1, 1'b1, 1'b1),
        mk(OP_REL,   8'd0,  2'd1, 2'd0, 5'd0,  1'b0, 1'b0, 1'b1),
        mk(OP_REL,   8'd0,  2'd0, 2'd1, 5'd0,  1'b0, 1'b0, 1'b1),
        mk(OP_REL,   8'd0,  2'd0, 2'd1, 5'd0,  1'b0, 1'b0, 1'b1),
        mk(OP_ALLOC, alc(2'd3, 3'd1, 1'b0, 1'b0), 2'd0, 2'd0, 5'd0, 1'b0, 1'b0, 1'b0),
        mk(OP_USB,   8'd4,  2'd0, 2'd0, 5'd0,  1'b0, 1'b0, 1'b0),
        mk(OP_ALLOC, alc(2'd0, 3'd0, 1'b1, 1'b0), 2'd0, 2'd0, 5'd0, 1'b0, 1'b0, 1'b0),
        mk(OP_ALLOC, alc(2'd3, 3'd2, 1'b1, 1'b0), 2'd0, 2'd0, 5'd0, 1'b0, 1'b0, 1'b0),
        mk(OP_ALLOC, alc(2'd1, 3'd1, 1'b1, 1'b1), 2'd0, 2'd0, 5'd0, 1'b0, 1'b1, 1'b1),
        mk(OP_WR,    8'd3,  2'd0, 2'd0, 5'd0,  1'b0, 1'b1, 1'b1),
        mk(OP_REL,   8'd0,  2'd1, 2'd0, 5'd0,  1'b0, 1'b0, 1'b1)
    };

    task automatic chk(input string req, input string what,
                       input logic [31:0] act, input logic [31:0] exp);
        total++;
        if (act !== exp) begin
            bad++;
            $display("FAIL %s %s actual=%0d expected=%0d", req, what, act, exp);
        end
    endtask

    task automatic apply_op(input logic [2:0] op, input logic [7:0] arg);
        @(negedge clk);
        case (op)
            OP_ALLOC: begin
                cfg_banks = arg[7:6]; cfg_size_code = arg[5:3];
                cfg_dir_in = arg[2]; cfg_ctrl = arg[1];
                cfg_alloc = 1'b1;
                @(negedge clk);
                cfg_alloc = 1'b0;
            end
            OP_WR: begin
                cpu_wr = 1'b1;
                repeat (int'(arg)) @(negedge clk);
                cpu_wr = 1'b0;
            end
            OP_RD: begin
                cpu_rd = 1'b1;
                repeat (int'(arg)) @(negedge clk);
                cpu_rd = 1'b0;
            end
            OP_REL: begin
                cpu_release = 1'b1;
                @(negedge clk);
                cpu_release = 1'b0;
            end
            OP_USB: begin
                usb_len = arg[CW-1:0]; usb_done = 1'b1;
                @(negedge clk);
                usb_done = 1'b0;
            end
            default: ;
        endcase
        repeat (4) @(negedge clk);
    endtask

    initial begin
        repeat (20000) @(posedge clk);
        bad++;
        $display("FAIL watchdog expired");
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        repeat (3) @(negedge clk);
        // R1 reset state
        chk("R1", "busy_cnt", 32'(busy_cnt), 0);
        chk("R1", "cur_bank", 32'(cur_bank), 0);
        chk("R1", "byte_cnt", 32'(byte_cnt), 0);
        chk("R1", "rw_allowed", 32'(rw_allowed), 0);
        chk("R1", "cfg_ok", 32'(cfg_ok), 0);
        chk("R1", "bank_int", 32'(bank_int), 0);
        chk("R1", "ctrl_dir", 32'(ctrl_dir), 0);
        rst_n = 1'b1;
        @(negedge clk);
        chk("R1", "cfg_ok after reset", 32'(cfg_ok), 0);

        // Table walk: R2 R3 R5 R6 R7 R8 R11 R13
        for (int i = 0; i < 30; i++) begin
            logic [31:0] v;
            string rq;
            v = VEC[i];
            apply_op(v[31:29], v[28:21]);
            case (v[31:29])
                OP_ALLOC: rq = "R2";
                OP_WR:    rq = "R3";
                OP_RD:    rq = "R8";
                OP_REL:   rq = "R5";
                default:  rq = "R6/R7";
            endcase
            chk(rq, $sformatf("step %0d busy_cnt", i), 32'(busy_cnt), 32'(v[20:19]));
            chk(rq, $sformatf("step %0d cur_bank", i), 32'(cur_bank), 32'(v[18:17]));
            chk(rq, $sformatf("step %0d byte_cnt", i), 32'(byte_cnt), 32'(v[16:12]));
            chk(rq, $sformatf("step %0d rw_allowed", i), 32'(rw_allowed), 32'(v[11]));
            chk("R11", $sformatf("step %0d bank_int", i), 32'(bank_int), 32'(v[10]));
            chk("R2", $sformatf("step %0d cfg_ok", i), 32'(cfg_ok), 32'(v[9]));
            chk("R13", $sformatf("step %0d cur_bank code", i), 32'(cur_bank != 2'b11), 1);
        end

        // R10: control endpoint never grants access, plain one does
        apply_op(OP_ALLOC, alc(2'd1, 3'd0, 1'b1, 1'b1));
        chk("R10", "rw_allowed ctrl", 32'(rw_allowed), 0);
        apply_op(OP_ALLOC, alc(2'd1, 3'd0, 1'b1, 1'b0));
        chk("R10", "rw_allowed non-ctrl", 32'(rw_allowed), 1);

        // R4: release pipeline timing
        apply_op(OP_ALLOC, alc(2'd3, 3'd0, 1'b1, 1'b0));
        apply_op(OP_WR, 8'd1);
        chk("R4", "byte_cnt before release", 32'(byte_cnt), 1);
        @(negedge clk); cpu_release = 1'b1;
        @(negedge clk);
        chk("R4", "cur_bank edge1", 32'(cur_bank), 0);
        chk("R4", "busy_cnt edge1", 32'(busy_cnt), 0);
        chk("R4", "rw_allowed edge1", 32'(rw_allowed), 0);
        @(negedge clk); cpu_release = 1'b0;
        chk("R4", "cur_bank edge2", 32'(cur_bank), 0);
        chk("R4", "busy_cnt edge2", 32'(busy_cnt), 0);
        @(negedge clk);
        chk("R4", "cur_bank edge3", 32'(cur_bank), 1);
        chk("R4", "busy_cnt edge3", 32'(busy_cnt), 1);
        chk("R4", "rw_allowed edge3", 32'(rw_allowed), 1);
        repeat (4) @(negedge clk);
        chk("R4", "second release ignored", 32'(busy_cnt), 1);
        chk("R4", "cur_bank settled", 32'(cur_bank), 1);

        // R9: stall and error block access
        stall_req = 1'b1; cpu_wr = 1'b1;
        @(negedge clk);
        chk("R9", "rw_allowed stall", 32'(rw_allowed), 0);
        @(negedge clk);
        stall_req = 1'b0; cpu_wr = 1'b0;
        chk("R9", "byte_cnt stall", 32'(byte_cnt), 0);
        @(negedge clk);
        chk("R9", "rw_allowed after stall", 32'(rw_allowed), 1);
        err_flag = 1'b1; cpu_wr = 1'b1;
        @(negedge clk);
        chk("R9", "rw_allowed err", 32'(rw_allowed), 0);
        @(negedge clk);
        err_flag = 1'b0; cpu_wr = 1'b0;
        chk("R9", "byte_cnt err", 32'(byte_cnt), 0);

        // R11: enable gates the interrupt
        int_en = 1'b0;
        apply_op(OP_ALLOC, alc(2'd3, 3'd0, 1'b1, 1'b0));
        chk("R11", "bank_int disabled", 32'(bank_int), 0);
        int_en = 1'b1;
        @(negedge clk);
        chk("R11", "bank_int enabled", 32'(bank_int), 1);

        // R12: direction after SETUP
        setup_dir_in = 1'b1; setup_done = 1'b1;
        @(negedge clk);
        setup_done = 1'b0; setup_dir_in = 1'b0;
        chk("R12", "ctrl_dir IN", 32'(ctrl_dir), 1);
        apply_op(OP_ALLOC, alc(2'd2, 3'd0, 1'b0, 1'b1));
        chk("R12", "ctrl_dir kept over alloc", 32'(ctrl_dir), 1);
        setup_done = 1'b1;
        @(negedge clk);
        setup_done = 1'b0;
        chk("R12", "ctrl_dir OUT", 32'(ctrl_dir), 0);

        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

endmodule